// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address for a user write after the translation cache has missed. It goes through a two-level table in memory: first a directory entry, then a page table entry. Both reads use a simple memory port that has one request outstanding at a time. At each level it checks the present, writable and user flags. The walk ends with a physical address or a fault code.

A walk starts when the requester presents a virtual address and a directory base while the walker is idle. The walker sequences the reads and performs the checks. When it finishes, it pulses `done_o` for one cycle. With that pulse it returns a status, the physical address and the final page table entry, which the requester can use to refill its translation cache. The fault kind is decided by the first level that fails. A walk that fails at the directory never touches the page table.

Top module: `pt_walker`

## Requirements
- R1: The first read of a walk is at address `dir_base_i + 4 * vaddr[31:22]`.
- R2: The second read is at address `{pde[31:12], 12'h000} + 4 * vaddr[21:12]`, where `pde` is the directory entry returned by the first read.
- R3: If the directory entry has bit 0 (present) clear, the walk ends with status 2'b01 (page fault) after exactly one read.
- R4: If the directory entry has bit 0 set but bit 1 (writable) or bit 2 (user) clear, the walk ends with status 2'b10 (protection fault) after exactly one read.
- R5: If the page table entry has bit 0 clear, the walk ends with status 2'b01 after two reads.
- R6: If the page table entry has bit 0 set but bit 1 or bit 2 clear, the walk ends with status 2'b10.
- R7: If both entries have bits 2:0 all set, the status is 2'b00 and `paddr_o = {pte[31:12], vaddr[11:0]}`.
- R8: At completion, `pte_o` holds the page table entry if one was read, and zero otherwise. `paddr_o` is zero on any fault.
- R9: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_ack_i` is seen. Read data is captured only in the cycle of the acknowledge, and an acknowledge may arrive in the same cycle as the request.
- R10: `done_o` is high for exactly one cycle per walk, and `status_o`, `paddr_o` and `pte_o` are valid in that cycle.
- R11: A walk request is accepted only while `req_ready_o` is high, which is only when the walker is idle. A request held high during a walk has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start a walk (taken only when idle) |
| req_ready_o | output | 1 | Walker idle, request will be taken |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_dir_base_i | input | 32 | Byte address of the directory |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read address |
| mem_ack_i | input | 1 | Memory read acknowledge, data valid |
| mem_rdata_i | input | 32 | Memory read data |
| done_o | output | 1 | One-cycle walk completion pulse |
| status_o | output | 2 | 00 ok, 01 page fault, 10 protection fault |
| paddr_o | output | 32 | Physical address on success, zero on fault |
| pte_o | output | 32 | Page table entry read, zero if none |

## Verification
The hardest situations to reach are timing cases at the memory port. One is an acknowledge in the same cycle a read is first requested. Another is a long wait during which the read data bus carries junk. A third is a new walk request held high through a walk that is still in progress. The bench's memory responder picks a random latency of zero to three cycles for each read and drives random junk on the read data whenever it is not acknowledging. Some directed walks keep the request line high with a different address and base for the whole walk. Randomly chosen flag bits in the entries mix faults at both levels with successful walks.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  typedef enum logic [1:0] {
    WALK_OK         = 2'd0,
    WALK_PAGE_FAULT = 2'd1,
    WALK_PROT_FAULT = 2'd2
  } walk_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_PDE,
    S_CHK_PDE,
    S_RD_PTE,
    S_CHK_PTE,
    S_DONE
  } walk_state_e;

  localparam int unsigned P_BIT = 0;
  localparam int unsigned W_BIT = 1;
  localparam int unsigned U_BIT = 2;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DIR_IDX_W = 10,
  parameter int unsigned TBL_IDX_W = 10,
  parameter int unsigned ENT_SHIFT = 2
) (
  input  logic [ADDR_W-1:0]                     vaddr_i,
  input  logic [ADDR_W-1:0]                     dir_base_i,
  input  logic [DIR_IDX_W+TBL_IDX_W-1:0]        pde_frame_i,
  output logic [ADDR_W-1:0]                     pde_addr_o,
  output logic [ADDR_W-1:0]                     pte_addr_o
);
  localparam int unsigned OFS_W = ADDR_W - DIR_IDX_W - TBL_IDX_W;

  logic [DIR_IDX_W-1:0] dir_idx;
  logic [TBL_IDX_W-1:0] tbl_idx;

  assign dir_idx = vaddr_i[ADDR_W-1 -: DIR_IDX_W];
  assign tbl_idx = vaddr_i[OFS_W +: TBL_IDX_W];

  assign pde_addr_o = dir_base_i + (ADDR_W'(dir_idx) << ENT_SHIFT);
  assign pte_addr_o = {pde_frame_i, {OFS_W{1'b0}}} + (ADDR_W'(tbl_idx) << ENT_SHIFT);
endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check
  import pt_walk_pkg::*;
(
  input  logic         present_i,
  input  logic         writable_i,
  input  logic         user_i,
  output walk_status_e status_o
);
  // user write needs all three; missing present wins over rights
  always_comb begin
    if (!present_i)                 status_o = WALK_PAGE_FAULT;
    else if (!(writable_i && user_i)) status_o = WALK_PROT_FAULT;
    else                            status_o = WALK_OK;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DIR_IDX_W = 10,
  parameter int unsigned TBL_IDX_W = 10,
  parameter int unsigned ENT_SHIFT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  input  logic [ADDR_W-1:0] req_dir_base_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic [ADDR_W-1:0] pte_o
);
  localparam int unsigned OFS_W   = ADDR_W - DIR_IDX_W - TBL_IDX_W;
  localparam int unsigned FRAME_W = ADDR_W - OFS_W;

  walk_state_e              state_q;
  logic [ADDR_W-1:0]        vaddr_q, base_q, pte_q, paddr_q;
  logic [FRAME_W-1:0]       pde_frame_q;
  logic                     pde_p_q, pde_w_q, pde_u_q;
  walk_status_e             status_q, pde_st, pte_st;
  logic [ADDR_W-1:0]        pde_addr, pte_addr;

  pt_addr_gen #(
    .ADDR_W(ADDR_W), .DIR_IDX_W(DIR_IDX_W),
    .TBL_IDX_W(TBL_IDX_W), .ENT_SHIFT(ENT_SHIFT)
  ) u_addr (
    .vaddr_i    (vaddr_q),
    .dir_base_i (base_q),
    .pde_frame_i(pde_frame_q),
    .pde_addr_o (pde_addr),
    .pte_addr_o (pte_addr)
  );

  pt_perm_check u_pde_chk (
    .present_i (pde_p_q),
    .writable_i(pde_w_q),
    .user_i    (pde_u_q),
    .status_o  (pde_st)
  );

  pt_perm_check u_pte_chk (
    .present_i (pte_q[P_BIT]),
    .writable_i(pte_q[W_BIT]),
    .user_i    (pte_q[U_BIT]),
    .status_o  (pte_st)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      vaddr_q     <= '0;
      base_q      <= '0;
      pde_frame_q <= '0;
      pde_p_q     <= 1'b0;
      pde_w_q     <= 1'b0;
      pde_u_q     <= 1'b0;
      pte_q       <= '0;
      paddr_q     <= '0;
      status_q    <= WALK_OK;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          vaddr_q  <= req_vaddr_i;
          base_q   <= req_dir_base_i;
          pte_q    <= '0;
          paddr_q  <= '0;
          status_q <= WALK_OK;
          state_q  <= S_RD_PDE;
        end
        S_RD_PDE: if (mem_ack_i) begin
          pde_frame_q <= mem_rdata_i[ADDR_W-1:OFS_W];
          pde_p_q     <= mem_rdata_i[P_BIT];
          pde_w_q     <= mem_rdata_i[W_BIT];
          pde_u_q     <= mem_rdata_i[U_BIT];
          state_q     <= S_CHK_PDE;
        end
        S_CHK_PDE: begin
          if (pde_st != WALK_OK) begin
            status_q <= pde_st;
            state_q  <= S_DONE;
          end else begin
            state_q  <= S_RD_PTE;
          end
        end
        S_RD_PTE: if (mem_ack_i) begin
          pte_q   <= mem_rdata_i;
          state_q <= S_CHK_PTE;
        end
        S_CHK_PTE: begin
          status_q <= pte_st;
          if (pte_st == WALK_OK)
            paddr_q <= {pte_q[ADDR_W-1:OFS_W], vaddr_q[OFS_W-1:0]};
          state_q <= S_DONE;
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign mem_req_o   = (state_q == S_RD_PDE) || (state_q == S_RD_PTE);
  assign mem_addr_o  = (state_q == S_RD_PTE) ? pte_addr : pde_addr;
  assign done_o      = (state_q == S_DONE);
  assign status_o    = status_q;
  assign paddr_o     = paddr_q;
  assign pte_o       = pte_q;

  // R9: request held with fixed address until acknowledged
  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7: success keeps the page offset and needs full rights in the entry
  a_r7_ok_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == WALK_OK) |->
      (paddr_o[OFS_W-1:0] == vaddr_q[OFS_W-1:0] && pte_o[U_BIT] && pte_o[W_BIT] && pte_o[P_BIT]));

  // R8: faults never return an address
  a_r8_fault_no_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o != WALK_OK) |-> (paddr_o == '0));

  // R11: idle means no memory traffic and no completion
  a_r11_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_req_o && !done_o));
endmodule

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic [31:0] req_dir_base_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        done_o;
  logic [1:0]  status_o;
  logic [31:0] paddr_o;
  logic [31:0] pte_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  pt_walker u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_vaddr_i, .req_dir_base_i,
    .mem_req_o, .mem_addr_o, .mem_ack_i, .mem_rdata_i,
    .done_o, .status_o, .paddr_o, .pte_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] flag_status(input logic [31:0] e);
    if (!e[0]) return 2'b01;
    if (!(e[1] && e[2])) return 2'b10;
    return 2'b00;
  endfunction

  task automatic walk(input logic [31:0] va, input logic [31:0] base,
                      input logic [31:0] pde, input logic [31:0] pte, input bit spam);
    logic [31:0] e_pde_a, e_pte_a, e_pa, e_pte, exp_a;
    logic [1:0]  e_st, d_st;
    int          e_reads, reads, cyc, wait_n;
    bit          got, a1_ok, a2_ok, ready_ok;
    string       st_tag;

    e_pde_a = base + {20'b0, va[31:22], 2'b00};
    e_pte_a = {pde[31:12], 12'h000} + {20'b0, va[21:12], 2'b00};
    d_st = flag_status(pde);
    if (d_st != 2'b00) begin
      e_st = d_st; e_reads = 1; e_pa = '0; e_pte = '0;
      st_tag = (d_st == 2'b01) ? "R3" : "R4";
    end else begin
      e_st = flag_status(pte); e_reads = 2; e_pte = pte;
      e_pa = (e_st == 2'b00) ? {pte[31:12], va[11:0]} : 32'h0;
      st_tag = (e_st == 2'b01) ? "R5" : (e_st == 2'b10) ? "R6" : "R7";
    end

    @(negedge clk_i);
    chk(req_ready_o === 1'b1, "R11 idle ready", {31'b0, req_ready_o}, 32'h1);
    req_valid_i = 1'b1; req_vaddr_i = va; req_dir_base_i = base;
    @(negedge clk_i);
    if (spam) begin
      req_vaddr_i = ~va; req_dir_base_i = base ^ 32'h0000_5000;
    end else req_valid_i = 1'b0;

    reads = 0; cyc = 0; got = 0; a1_ok = 1; a2_ok = 1; ready_ok = 1;
    wait_n = $urandom_range(0, 3);
    while (!got && cyc < 60) begin
      mem_ack_i = 1'b0;
      mem_rdata_i = $urandom;
      if (done_o) got = 1;
      else begin
        if (req_ready_o) ready_ok = 0;
        if (mem_req_o) begin
          exp_a = (reads == 0) ? e_pde_a : e_pte_a;
          if (reads == 0 && mem_addr_o !== exp_a) a1_ok = 0;
          if (reads >= 1 && mem_addr_o !== exp_a) a2_ok = 0;
          if (wait_n == 0) begin
            mem_ack_i = 1'b1;
            mem_rdata_i = (reads == 0) ? pde : pte;
            reads++;
            wait_n = $urandom_range(0, 3);
          end else wait_n--;
        end
        @(negedge clk_i);
        cyc++;
      end
    end
    req_valid_i = 1'b0;

    chk(got, "R10 done seen", {31'b0, got}, 32'h1);
    chk(a1_ok, "R1 directory address", mem_addr_o, e_pde_a);
    chk(a2_ok, "R2 table address", mem_addr_o, e_pte_a);
    chk(reads == e_reads, "R9 read count", reads, e_reads);
    chk(status_o === e_st, st_tag, {30'b0, status_o}, {30'b0, e_st});
    chk(paddr_o === e_pa, "R7 R8 paddr", paddr_o, e_pa);
    chk(pte_o === e_pte, "R8 pte", pte_o, e_pte);
    chk(ready_ok, "R11 not ready during walk", 32'h0, 32'h1);
    @(negedge clk_i);
    chk(done_o === 1'b0, "R10 pulse width", {31'b0, done_o}, 32'h0);
    chk(mem_req_o === 1'b0, "R11 held request ignored", {31'b0, mem_req_o}, 32'h0);
    chk(req_ready_o === 1'b1, "R11 back to idle", {31'b0, req_ready_o}, 32'h1);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] va, base, pde, pte;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    chk(req_ready_o === 1'b1, "R11 reset ready", {31'b0, req_ready_o}, 32'h1);
    chk(mem_req_o === 1'b0, "R9 reset no request", {31'b0, mem_req_o}, 32'h0);
    chk(done_o === 1'b0, "R10 reset no done", {31'b0, done_o}, 32'h0);
    rst_ni = 1'b1;

    // R3: directory not present
    walk(32'h1b2e_447c, 32'h0036_a000, 32'h0003_2026, 32'h0, 0);
    // R5: table entry not present
    walk(32'h4c60_b80c, 32'h0036_a000, 32'h003f_b027, 32'h0014_a006, 0);
    // R6: table entry not writable
    walk(32'h7ce9_fe7c, 32'h0036_a000, 32'h0006_1027, 32'h0024_8025, 0);
    // R7: success
    walk(32'h4c60_b80c, 32'h0036_a000, 32'h003f_b027, 32'h003c_0067, 0);
    // R4: directory present but not user
    walk(32'h1234_5678, 32'h0010_0000, 32'h0006_1003, 32'h003c_0067, 0);
    // R4: directory present but not writable
    walk(32'hffff_ffff, 32'hfff0_0000, 32'h0006_1005, 32'h003c_0067, 1);
    // R11: held request through a successful walk
    walk(32'h0000_0000, 32'h0000_0000, 32'hffff_f007, 32'hffff_f007, 1);

    for (int i = 0; i < 60; i++) begin
      va   = $urandom;
      base = {$urandom_range(0, 32'hf_ffff), 12'h000};
      pde  = $urandom;
      pte  = $urandom;
      if ($urandom_range(0, 9) < 7) pde[2:0] = 3'b111;
      if ($urandom_range(0, 9) < 6) pte[2:0] = 3'b111;
      walk(va, base, pde, pte, $urandom_range(0, 3) == 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule